// File: doc/BRIEF.md
# Divergent Warp Reconvergence Barrier Unit

This unit handles branch divergence for narrow warps, each exactly as wide as the SIMD datapath. It does not keep a per-warp stack of paths. When a branch splits a warp, the unit retires the original warp and creates two independent path warps. The scheduler may run these path warps in any order. One path warp holds the lanes that took the branch and starts at the branch target. The other holds the remaining lanes and starts at the fall-through address.

At the same time the unit reserves a barrier entry, keyed by the warp-group identifier and the join PC. The entry records which lanes must arrive at the join point. When a path warp reaches the join PC, it reports its lane mask. Once the arrived lanes cover the expected mask, the entry is freed and the unit emits a release event. That event revives one warp at the join PC with the merged mask.

The entries live in a set-associative table. The set is chosen by the low bits of the join PC, and each set holds several ways. A divergent branch that finds its set full is held off with a not-ready handshake. Every lane keeps its own bit position in every mask, so merging masks is a plain bitwise OR.

Top module: `dvb_unit`

## Requirements
- R1: After synchronous reset, every event output (`tk_valid`, `nt_valid`, `kill_valid`, `rel_valid`) is low, and the barrier table is empty.
- R2: An accepted branch whose taken mask covers every active lane produces, one cycle later, only a taken event. That event carries the target PC, the full active mask and the branch group. No kill event is produced and no barrier entry is reserved.
- R3: An accepted branch with no active lane taken produces, one cycle later, only a not-taken event at the fall-through PC with the full active mask. No kill event is produced.
- R4: An accepted branch with some active lanes taken and some not produces, one cycle later, three events at once. These are a kill event for the original warp, a taken event at the target PC with mask `act & tkn`, and a not-taken event at the fall-through PC with mask `act & ~tkn`. Lane bits outside `act` are ignored.
- R5: A divergent branch reserves an entry whose expected mask is its active mask. Each arrival with a matching group and join PC ORs its mask into the entry. While the OR differs from the expected mask, no release occurs. The arrival that makes the OR equal the expected mask causes a release event one cycle later, carrying the group, the join PC and the expected mask, and it frees the entry.
- R6: An arrival that matches no live entry has no effect. It produces no release, and a later correct completion of any live entry behaves normally.
- R7: The set index is `join_pc[3:0]` (log2 of SETS low bits), and each set has 8 ways. Suppose a divergent branch arrives while all 8 ways of its set hold live entries. Then `br_ready` is low, no event follows, and nothing is reserved. A divergent branch whose set has room is accepted. Uniform branches are always ready.
- R8: Suppose an arrival completes an entry in the same cycle that a divergent branch targets that entry's full set. Then the release is processed first, so the branch is accepted into the freed way and both events appear in the next cycle.
- R9: A path warp may itself diverge. This reserves a second, independent entry, and the inner and outer barriers release separately.
- R10: The tag covers the group identifier and the join PC bits above the set index. An arrival that differs from a live entry only in group, or only in upper PC bits, does not touch that entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_valid | input | 1 | Branch resolution event present |
| br_ready | output | 1 | Branch event can be accepted this cycle |
| br_gid | input | GID_W | Warp-group identifier of the branching warp |
| br_act | input | LANES | Active lane mask of the branching warp |
| br_tkn | input | LANES | Per-lane taken outcome |
| br_tgt_pc | input | PC_W | Branch target PC |
| br_fall_pc | input | PC_W | Fall-through PC |
| br_join_pc | input | PC_W | Reconvergence PC |
| arr_valid | input | 1 | A path warp has reached its join point |
| arr_gid | input | GID_W | Group of the arriving path warp |
| arr_pc | input | PC_W | Join PC reached |
| arr_mask | input | LANES | Lanes of the arriving path warp |
| ev_gid | output | GID_W | Group of the branch events below |
| tk_valid | output | 1 | Create/continue warp on the taken path |
| tk_pc | output | PC_W | PC of the taken-path warp |
| tk_mask | output | LANES | Lanes of the taken-path warp |
| nt_valid | output | 1 | Create/continue warp on the not-taken path |
| nt_pc | output | PC_W | PC of the not-taken-path warp |
| nt_mask | output | LANES | Lanes of the not-taken-path warp |
| kill_valid | output | 1 | Original warp invalidated by divergence |
| rel_valid | output | 1 | A barrier completed; revive a warp |
| rel_gid | output | GID_W | Group of the revived warp |
| rel_pc | output | PC_W | Join PC of the revived warp |
| rel_mask | output | LANES | Merged lane mask of the revived warp |

## Verification
The assertions rely on several properties of the inputs. At most one live entry exists per group and join PC. Every arrival carries lanes that belong to the live entry it targets, and no lane arrives twice. Branch active masks are non-zero. Under these conditions an arrival hits at most one way, and a release always follows an arrival.

The stimulus obeys these rules throughout. Each sweep branch uses its own join PC. Arrival masks are exactly the path masks the unit emitted. Arrivals that deliberately miss use a group or upper PC bits that no live entry holds.

// File: rtl/dvb_pkg.sv
package dvb_pkg;
  typedef enum logic [1:0] {
    CLS_ALL_TAKEN = 2'd0,
    CLS_NONE_TAKEN = 2'd1,
    CLS_SPLIT = 2'd2
  } br_cls_e;
endpackage

// File: rtl/dvb_branch_split.sv
module dvb_branch_split #(
  parameter int LANES = 4
) (
  input  logic [LANES-1:0] act,
  input  logic [LANES-1:0] tkn,
  output dvb_pkg::br_cls_e cls,
  output logic [LANES-1:0] tk_mask,
  output logic [LANES-1:0] nt_mask
);
  always_comb begin
    tk_mask = act & tkn;
    nt_mask = act & ~tkn;
    if (nt_mask == '0)      cls = dvb_pkg::CLS_ALL_TAKEN;
    else if (tk_mask == '0) cls = dvb_pkg::CLS_NONE_TAKEN;
    else                    cls = dvb_pkg::CLS_SPLIT;
  end
endmodule

// File: rtl/dvb_way_pick.sv
module dvb_way_pick #(
  parameter int WAYS = 8
) (
  input  logic [WAYS-1:0] free,
  output logic [WAYS-1:0] grant,
  output logic            found
);
  always_comb begin
    grant = '0;
    found = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (free[w] && !found) begin
        grant[w] = 1'b1;
        found    = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dvb_set_match.sv
module dvb_set_match #(
  parameter int WAYS  = 8,
  parameter int TAG_W = 16
) (
  input  logic [WAYS-1:0]       vld,
  input  logic [WAYS*TAG_W-1:0] tags,
  input  logic [TAG_W-1:0]      key,
  output logic [WAYS-1:0]       hit,
  output logic                  any
);
  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_cmp
      assign hit[w] = vld[w] && (tags[w*TAG_W +: TAG_W] == key);
    end
  endgenerate
  assign any = |hit;
endmodule

// File: rtl/dvb_unit.sv
module dvb_unit #(
  parameter int LANES = 4,
  parameter int PC_W  = 16,
  parameter int GID_W = 4,
  parameter int SETS  = 16,
  parameter int WAYS  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             br_valid,
  output logic             br_ready,
  input  logic [GID_W-1:0] br_gid,
  input  logic [LANES-1:0] br_act,
  input  logic [LANES-1:0] br_tkn,
  input  logic [PC_W-1:0]  br_tgt_pc,
  input  logic [PC_W-1:0]  br_fall_pc,
  input  logic [PC_W-1:0]  br_join_pc,
  input  logic             arr_valid,
  input  logic [GID_W-1:0] arr_gid,
  input  logic [PC_W-1:0]  arr_pc,
  input  logic [LANES-1:0] arr_mask,
  output logic [GID_W-1:0] ev_gid,
  output logic             tk_valid,
  output logic [PC_W-1:0]  tk_pc,
  output logic [LANES-1:0] tk_mask,
  output logic             nt_valid,
  output logic [PC_W-1:0]  nt_pc,
  output logic [LANES-1:0] nt_mask,
  output logic             kill_valid,
  output logic             rel_valid,
  output logic [GID_W-1:0] rel_gid,
  output logic [PC_W-1:0]  rel_pc,
  output logic [LANES-1:0] rel_mask
);
  localparam int IDX_W = $clog2(SETS);
  localparam int WAY_W = $clog2(WAYS);
  localparam int ENT   = SETS * WAYS;
  localparam int ENT_W = IDX_W + WAY_W;
  localparam int TAG_W = GID_W + PC_W - IDX_W;

  // barrier table storage, one slot per (set, way)
  logic [ENT-1:0]   vld_q;
  logic [TAG_W-1:0] tag_q [ENT];
  logic [LANES-1:0] exp_q [ENT];
  logic [LANES-1:0] got_q [ENT];

  // branch classification
  dvb_pkg::br_cls_e cls;
  logic [LANES-1:0] sp_tk, sp_nt;

  dvb_branch_split #(.LANES(LANES)) u_split (
    .act(br_act), .tkn(br_tkn), .cls(cls), .tk_mask(sp_tk), .nt_mask(sp_nt)
  );

  // set selection and keys
  logic [IDX_W-1:0] b_idx, a_idx;
  logic [TAG_W-1:0] b_key, a_key;
  assign b_idx = br_join_pc[IDX_W-1:0];
  assign a_idx = arr_pc[IDX_W-1:0];
  assign b_key = {br_gid, br_join_pc[PC_W-1:IDX_W]};
  assign a_key = {arr_gid, arr_pc[PC_W-1:IDX_W]};

  // per-way views of the two addressed sets
  logic [WAYS-1:0]       b_vld, a_vld;
  logic [WAYS*TAG_W-1:0] a_tags;
  logic [LANES-1:0]      a_exp [WAYS];
  logic [LANES-1:0]      a_got [WAYS];

  genvar w;
  generate
    for (w = 0; w < WAYS; w++) begin : g_way
      localparam logic [WAY_W-1:0] WI = WAY_W'(w);
      assign b_vld[w] = vld_q[{b_idx, WI}];
      assign a_vld[w] = vld_q[{a_idx, WI}];
      assign a_tags[w*TAG_W +: TAG_W] = tag_q[{a_idx, WI}];
      assign a_exp[w] = exp_q[{a_idx, WI}];
      assign a_got[w] = got_q[{a_idx, WI}];
    end
  endgenerate

  // arrival lookup
  logic [WAYS-1:0] a_hit;
  logic            a_any;

  dvb_set_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .vld(a_vld), .tags(a_tags), .key(a_key), .hit(a_hit), .any(a_any)
  );

  logic [WAY_W-1:0] a_way;
  logic [LANES-1:0] a_sel_exp, a_sel_got, a_merge;
  logic             a_done;

  always_comb begin
    a_way     = '0;
    a_sel_exp = '0;
    a_sel_got = '0;
    for (int i = 0; i < WAYS; i++) begin
      if (a_hit[i]) begin
        a_way     = WAY_W'(i);
        a_sel_exp = a_sel_exp | a_exp[i];
        a_sel_got = a_sel_got | a_got[i];
      end
    end
    a_merge = a_sel_got | arr_mask;
    a_done  = arr_valid && a_any && (a_merge == a_sel_exp);
  end

  // reservation: a way freed by a completing arrival in the same set counts as free
  logic [WAYS-1:0] b_free, b_grant;
  logic            b_found;
  logic [WAY_W-1:0] b_way;
  logic            br_acc;

  assign b_free = ~b_vld | ((a_done && (a_idx == b_idx)) ? a_hit : '0);

  dvb_way_pick #(.WAYS(WAYS)) u_pick (
    .free(b_free), .grant(b_grant), .found(b_found)
  );

  always_comb begin
    b_way = '0;
    for (int i = 0; i < WAYS; i++)
      if (b_grant[i]) b_way = WAY_W'(i);
  end

  assign br_ready = (cls != dvb_pkg::CLS_SPLIT) || b_found;
  assign br_acc   = br_valid && br_ready;

  logic [ENT_W-1:0] a_ent, b_ent;
  assign a_ent = {a_idx, a_way};
  assign b_ent = {b_idx, b_way};

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q      <= '0;
      tk_valid   <= 1'b0;
      nt_valid   <= 1'b0;
      kill_valid <= 1'b0;
      rel_valid  <= 1'b0;
      ev_gid     <= '0;
      tk_pc      <= '0;
      tk_mask    <= '0;
      nt_pc      <= '0;
      nt_mask    <= '0;
      rel_gid    <= '0;
      rel_pc     <= '0;
      rel_mask   <= '0;
    end else begin
      tk_valid   <= 1'b0;
      nt_valid   <= 1'b0;
      kill_valid <= 1'b0;
      rel_valid  <= 1'b0;
      // arrivals first so a freed way can be reserved in the same cycle
      if (arr_valid && a_any) begin
        if (a_done) begin
          vld_q[a_ent] <= 1'b0;
          rel_valid    <= 1'b1;
          rel_gid      <= arr_gid;
          rel_pc       <= arr_pc;
          rel_mask     <= a_sel_exp;
        end else begin
          got_q[a_ent] <= a_merge;
        end
      end
      if (br_acc) begin
        ev_gid <= br_gid;
        tk_pc  <= br_tgt_pc;
        nt_pc  <= br_fall_pc;
        case (cls)
          dvb_pkg::CLS_ALL_TAKEN: begin
            tk_valid <= 1'b1;
            tk_mask  <= br_act;
          end
          dvb_pkg::CLS_NONE_TAKEN: begin
            nt_valid <= 1'b1;
            nt_mask  <= br_act;
          end
          default: begin
            tk_valid     <= 1'b1;
            nt_valid     <= 1'b1;
            kill_valid   <= 1'b1;
            tk_mask      <= sp_tk;
            nt_mask      <= sp_nt;
            vld_q[b_ent] <= 1'b1;
            tag_q[b_ent] <= b_key;
            exp_q[b_ent] <= br_act;
            got_q[b_ent] <= '0;
          end
        endcase
      end
    end
  end

  // a held-off branch leaves no trace on the outputs
  assert_stall_silent_R7: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !br_ready) |=> (!tk_valid && !nt_valid && !kill_valid));

  // a split always emits two disjoint non-empty path warps
  assert_split_disjoint_R4: assert property (@(posedge clk) disable iff (rst)
    kill_valid |-> (tk_valid && nt_valid && ((tk_mask & nt_mask) == '0)
                    && (tk_mask != '0) && (nt_mask != '0)));

  // a uniform outcome yields exactly one path warp and no kill
  assert_uniform_one_R2: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_ready && (br_act != '0) && ((br_act & ~br_tkn) == '0))
      |=> (tk_valid && !nt_valid && !kill_valid && tk_mask == $past(br_act)));

  assert_uniform_one_R3: assert property (@(posedge clk) disable iff (rst)
    (br_valid && br_ready && (br_act != '0) && ((br_act & br_tkn) == '0))
      |=> (nt_valid && !tk_valid && !kill_valid && nt_mask == $past(br_act)));

  // a release always follows an arrival at the same join PC
  assert_release_cause_R5: assert property (@(posedge clk) disable iff (rst)
    rel_valid |-> ($past(arr_valid) && rel_pc == $past(arr_pc)
                   && rel_gid == $past(arr_gid) && rel_mask != '0));

  // tags are unique per set, so an arrival hits at most one way
  assert_single_hit_R10: assert property (@(posedge clk) disable iff (rst)
    arr_valid |-> ($countones(a_hit) <= 1));

  // reservation picks at most one way and only a free one
  assert_grant_free_R8: assert property (@(posedge clk) disable iff (rst)
    br_valid |-> ($onehot0(b_grant) && ((b_grant & ~b_free) == '0)));
endmodule

// File: tb/dvb_unit_tb.sv
`timescale 1ns/1ps
module dvb_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        br_valid = 0, arr_valid = 0;
  logic        br_ready;
  logic [3:0]  br_gid = 0, br_act = 0, br_tkn = 0, arr_gid = 0, arr_mask = 0;
  logic [15:0] br_tgt_pc = 0, br_fall_pc = 0, br_join_pc = 0, arr_pc = 0;
  logic [3:0]  ev_gid, tk_mask, nt_mask, rel_gid, rel_mask;
  logic [15:0] tk_pc, nt_pc, rel_pc;
  logic        tk_valid, nt_valid, kill_valid, rel_valid;

  int n_tests = 0;
  int n_fail  = 0;

  dvb_unit u_dut (
    .clk(clk), .rst(rst),
    .br_valid(br_valid), .br_ready(br_ready), .br_gid(br_gid), .br_act(br_act),
    .br_tkn(br_tkn), .br_tgt_pc(br_tgt_pc), .br_fall_pc(br_fall_pc), .br_join_pc(br_join_pc),
    .arr_valid(arr_valid), .arr_gid(arr_gid), .arr_pc(arr_pc), .arr_mask(arr_mask),
    .ev_gid(ev_gid), .tk_valid(tk_valid), .tk_pc(tk_pc), .tk_mask(tk_mask),
    .nt_valid(nt_valid), .nt_pc(nt_pc), .nt_mask(nt_mask), .kill_valid(kill_valid),
    .rel_valid(rel_valid), .rel_gid(rel_gid), .rel_pc(rel_pc), .rel_mask(rel_mask)
  );

  task automatic chk(input string req, input logic [31:0] actual, input logic [31:0] expected);
    n_tests++;
    if (actual !== expected) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, actual, expected);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  // one branch event; outputs checked one cycle after acceptance
  task automatic do_br(input logic [3:0] g, input logic [3:0] a, input logic [3:0] t,
                       input logic [15:0] tp, input logic [15:0] fp, input logic [15:0] jp,
                       input bit exp_rdy);
    logic [3:0] etk, ent;
    string req;
    etk = a & t;
    ent = a & ~t;
    req = (etk != 0 && ent != 0) ? "R4" : ((ent == 0) ? "R2" : "R3");
    @(negedge clk);
    br_valid = 1; br_gid = g; br_act = a; br_tkn = t;
    br_tgt_pc = tp; br_fall_pc = fp; br_join_pc = jp;
    #1;
    chk(exp_rdy ? req : "R7", {31'd0, br_ready}, {31'd0, exp_rdy});
    @(negedge clk);
    br_valid = 0;
    if (!exp_rdy) begin
      chk("R7", {29'd0, tk_valid, nt_valid, kill_valid}, 32'd0);
    end else begin
      chk(req, {29'd0, tk_valid, nt_valid, kill_valid},
          {29'd0, etk != 0, ent != 0, (etk != 0 && ent != 0)});
      chk(req, {28'd0, ev_gid}, {28'd0, g});
      if (etk != 0) chk(req, {tk_pc, 12'd0, tk_mask}, {tp, 12'd0, etk});
      if (ent != 0) chk(req, {nt_pc, 12'd0, nt_mask}, {fp, 12'd0, ent});
    end
  endtask

  task automatic do_arr(input logic [3:0] g, input logic [15:0] pc, input logic [3:0] m,
                        input bit exp_rel, input logic [3:0] exp_mask, input string req);
    @(negedge clk);
    arr_valid = 1; arr_gid = g; arr_pc = pc; arr_mask = m;
    @(negedge clk);
    arr_valid = 0;
    chk(req, {31'd0, rel_valid}, {31'd0, exp_rel});
    if (exp_rel) chk(req, {rel_pc, 8'd0, rel_gid, rel_mask}, {pc, 8'd0, g, exp_mask});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired (all requirements)");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1", {28'd0, tk_valid, nt_valid, kill_valid, rel_valid}, 32'd0);
    chk("R1", {31'd0, br_ready}, 32'd1);
    // R6 arrival into an empty table
    do_arr(4'd1, 16'h0042, 4'hF, 1'b0, 4'h0, "R6");

    // near-exhaustive sweep of active/taken masks (R2 R3 R4 R5)
    for (int a = 1; a < 16; a++) begin
      for (int t = 0; t < 16; t++) begin
        logic [3:0] am, tm, etk, ent;
        logic [15:0] jp;
        am = 4'(a); tm = 4'(t);
        etk = am & tm; ent = am & ~tm;
        jp = 16'h1000 | (16'(a) << 8) | (16'(t) << 4) | 16'(a);
        do_br(tm, am, tm, 16'h2000 + 16'(a * 16 + t), 16'h3000 + 16'(a * 16 + t), jp, 1'b1);
        if (etk != 0 && ent != 0) begin
          if (t[0]) begin
            do_arr(tm, jp, ent, 1'b0, 4'h0, "R5");
            do_arr(tm, jp, etk, 1'b1, am, "R5");
          end else begin
            do_arr(tm, jp, etk, 1'b0, 4'h0, "R5");
            do_arr(tm, jp, ent, 1'b1, am, "R5");
          end
        end
      end
    end

    // R7 fill set 5 with eight live barriers
    for (int k = 0; k < 8; k++)
      do_br(4'd1, 4'hF, 4'h5, 16'h4000, 16'h5000, 16'h0005 + 16'(k * 16), 1'b1);
    do_br(4'd1, 4'hF, 4'h5, 16'h4000, 16'h5000, 16'h0095, 1'b0);
    do_br(4'd1, 4'hF, 4'h0, 16'h4000, 16'h5000, 16'h0095, 1'b1);  // uniform still ready
    do_br(4'd1, 4'hF, 4'h5, 16'h4100, 16'h5100, 16'h0006, 1'b1);  // other set has room
    do_arr(4'd1, 16'h0006, 4'hF, 1'b1, 4'hF, "R7");

    // R8 release and reservation in the same full set, same cycle
    do_arr(4'd1, 16'h0005, 4'h5, 1'b0, 4'h0, "R8");
    @(negedge clk);
    br_valid = 1; br_gid = 4'd1; br_act = 4'hF; br_tkn = 4'h3;
    br_tgt_pc = 16'h4200; br_fall_pc = 16'h5200; br_join_pc = 16'h0095;
    arr_valid = 1; arr_gid = 4'd1; arr_pc = 16'h0005; arr_mask = 4'hA;
    #1;
    chk("R8", {31'd0, br_ready}, 32'd1);
    @(negedge clk);
    br_valid = 0; arr_valid = 0;
    chk("R8", {29'd0, rel_valid, kill_valid, tk_valid}, 32'd7);
    chk("R8", {rel_pc, 12'd0, rel_mask}, {16'h0005, 12'd0, 4'hF});
    chk("R8", {24'd0, tk_mask, nt_mask}, {24'd0, 4'h3, 4'hC});
    for (int k = 1; k < 8; k++)
      do_arr(4'd1, 16'h0005 + 16'(k * 16), 4'hF, 1'b1, 4'hF, "R7");
    do_arr(4'd1, 16'h0095, 4'h3, 1'b0, 4'h0, "R8");
    do_arr(4'd1, 16'h0095, 4'hC, 1'b1, 4'hF, "R8");

    // R10 / R6 near-miss arrivals do not touch a live entry
    do_br(4'd2, 4'hF, 4'h9, 16'h4300, 16'h5300, 16'h0207, 1'b1);
    do_arr(4'd3, 16'h0207, 4'hF, 1'b0, 4'h0, "R10");
    do_arr(4'd2, 16'h0217, 4'hF, 1'b0, 4'h0, "R10");
    do_arr(4'd2, 16'h0208, 4'hF, 1'b0, 4'h0, "R6");
    do_arr(4'd2, 16'h0207, 4'h9, 1'b0, 4'h0, "R6");
    do_arr(4'd2, 16'h0207, 4'h6, 1'b1, 4'hF, "R6");

    // R9 nested divergence
    do_br(4'd4, 4'hF, 4'h3, 16'h0400, 16'h0500, 16'h0300, 1'b1);
    do_br(4'd4, 4'h3, 4'h1, 16'h0600, 16'h0700, 16'h0280, 1'b1);
    do_arr(4'd4, 16'h0280, 4'h1, 1'b0, 4'h0, "R9");
    do_arr(4'd4, 16'h0300, 4'hC, 1'b0, 4'h0, "R9");
    do_arr(4'd4, 16'h0280, 4'h2, 1'b1, 4'h3, "R9");
    do_arr(4'd4, 16'h0300, 4'h3, 1'b1, 4'hF, "R9");

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule